// File: doc/BRIEF.md
# Preamble and Mark Pattern Detectors

This block watches a received serial bit stream that arrives one bit per bit-rate strobe. It raises two detect flags. The mark flag reports a long run of continuous ones. The preamble flag reports a long run of alternating ones and zeros. A pattern qualifies after a parameterised number of consecutive matching bits, 32 by default. After a pattern ends, its flag stays raised for a fixed number of bit times, 12 by default. A receiver uses the flags to tell that the line is idling in mark, or that a channel-seizure preamble is present, before it starts framing data.

A single-cycle configuration-change pulse clears both detectors. The surrounding receiver raises this pulse whenever the bit rate or the operating mode is reprogrammed. The detectors then restart from an empty history. Demodulation and register access are handled elsewhere.

Top module: `bitpat_detect`

## Requirements
- R1: While reset is asserted and after it is released, both `mark_det` and `alt_det` read 0 until a pattern qualifies.
- R2: `mark_det` becomes 1 right after the clock edge that carries the strobe of the 32nd consecutive 1 bit, and not after only 31.
- R3: `alt_det` becomes 1 right after the clock edge that carries the strobe of the 32nd consecutive bit in which each bit differs from the one before it. This holds whether the run starts with 0 or with 1.
- R4: A bit that breaks a pattern restarts that pattern's run. For the alternating pattern, the breaking bit (equal to its predecessor) is itself the first bit of a new run, so 31 further alternating bits after it qualify again.
- R5: Let the last qualifying strobe be the one whose bit completes or extends a 32-bit run. A flag stays 1 through the next 11 strobes and falls right after the edge carrying the 12th strobe after that qualifying strobe.
- R6: `cfg_chg` high at a clock edge clears both flags and both run histories at that edge. It takes priority over a strobe in the same cycle.
- R7: In cycles without `bit_stb`, `rx_bit` is ignored. Neither flag, run, nor hold count changes.
- R8: Run counts saturate, so a pattern lasting much longer than 32 bits keeps its flag continuously at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle strobe marking a valid received bit |
| rx_bit | input | 1 | Received bit, sampled when `bit_stb` is 1 |
| cfg_chg | input | 1 | One-cycle pulse on bit-rate or mode change; clears both detectors |
| mark_det | output | 1 | Continuous-ones detect flag |
| alt_det | output | 1 | Alternating-pattern detect flag |

## Verification
Each flag is the only visible sign of its run and hold counters. A wrong run count shows as a flag that rises one or more strobes early or late relative to the 32nd matching bit. A wrong hold count shows as a flag that falls at the wrong strobe after a break. A behavioural model keeps the last 32 received bits and the number of strobes since the last qualifying bit. It is compared with both flags after every clock, so a divergence is reported in the cycle it first reaches a port. Sequences that break the alternating run, strobe-free gaps during the hold period, and a configuration pulse that coincides with a strobe target the corner cases.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
   typedef enum logic {
      PAT_MARK = 1'b0,
      PAT_ALT  = 1'b1
   } pat_kind_e;
endpackage

// File: rtl/bpd_run_track.sv
module bpd_run_track #(
   parameter bpd_pkg::pat_kind_e KIND = bpd_pkg::PAT_MARK,
   parameter int QUAL = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic stb,
   input  logic bit_in,
   output logic hit
);
   localparam int CW = $clog2(QUAL + 1);
   localparam logic [CW-1:0] QMAX = CW'(QUAL);

   logic [CW-1:0] run_q, run_d, run_inc;
   logic          prev_q;

   generate
      if (QUAL < 2) begin : g_bad_qual
         $error("bpd_run_track: QUAL must be at least 2");
      end
   endgenerate

   assign run_inc = (run_q == QMAX) ? run_q : run_q + CW'(1);

   generate
      if (KIND == bpd_pkg::PAT_MARK) begin : g_mark
         always_comb run_d = bit_in ? run_inc : '0;
      end else begin : g_alt
         always_comb begin
            if (run_q == '0)          run_d = CW'(1);
            else if (bit_in != prev_q) run_d = run_inc;
            else                       run_d = CW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         run_q  <= '0;
         prev_q <= 1'b0;
      end else if (stb) begin
         run_q  <= run_d;
         prev_q <= bit_in;
      end
   end

   assign hit = stb && !clr && (run_d == QMAX);

   assert_run_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= QMAX);
   assert_clear_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (run_q == '0));
   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb && !clr) |=> $stable(run_q));

   generate
      if (KIND == bpd_pkg::PAT_MARK) begin : g_mark_chk
         assert_zero_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (stb && !clr && !bit_in) |=> (run_q == '0));
      end else begin : g_alt_chk
         assert_alt_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (stb && !clr) |=> (run_q != '0));
      end
   endgenerate
endmodule

// File: rtl/bpd_hold.sv
module bpd_hold #(
   parameter int HOLD = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic stb,
   input  logic hit,
   output logic flag
);
   localparam int HW = $clog2(HOLD + 1);
   localparam logic [HW-1:0] HMAX = HW'(HOLD);

   logic [HW-1:0] hold_q;

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("bpd_hold: HOLD must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr)                hold_q <= '0;
      else if (hit)                     hold_q <= HMAX;
      else if (stb && hold_q != '0)     hold_q <= hold_q - HW'(1);
   end

   assign flag = (hold_q != '0);

   assert_hit_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);
   assert_clear_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !flag);
   assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb && !clr) |=> $stable(hold_q));
   assert_fall_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> ($past(stb) || $past(clr)));
endmodule

// File: rtl/bitpat_detect.sv
module bitpat_detect #(
   parameter int QUAL_LEN  = 32,
   parameter int HOLD_BITS = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_stb,
   input  logic rx_bit,
   input  logic cfg_chg,
   output logic mark_det,
   output logic alt_det
);
   localparam int NDET = 2;

   logic [NDET-1:0] hit_v;
   logic [NDET-1:0] flag_v;

   generate
      for (genvar k = 0; k < NDET; k++) begin : g_det
         localparam bpd_pkg::pat_kind_e KK =
            (k == 0) ? bpd_pkg::PAT_MARK : bpd_pkg::PAT_ALT;
         bpd_run_track #(.KIND(KK), .QUAL(QUAL_LEN)) u_run (
            .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .stb(bit_stb),
            .bit_in(rx_bit), .hit(hit_v[k]));
         bpd_hold #(.HOLD(HOLD_BITS)) u_hold (
            .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .stb(bit_stb),
            .hit(hit_v[k]), .flag(flag_v[k]));
      end
   endgenerate

   assign mark_det = flag_v[0];
   assign alt_det  = flag_v[1];

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!mark_det && !alt_det));
   assert_rise_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(alt_det) || $rose(mark_det)) |-> $past(bit_stb));
   assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_v[0] && hit_v[1]));
endmodule

// File: tb/sim_bitpat_detect.sv
module sim_bitpat_detect;
   logic clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0, rx_bit = 1'b0, cfg_chg = 1'b0;
   logic mark_det, alt_det;
   int checks = 0, errors = 0;
   bit done = 0;

   bitpat_detect u0 (.clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
      .cfg_chg(cfg_chg), .mark_det(mark_det), .alt_det(alt_det));

   always #2.5 clk = ~clk;

   bit hist[$];
   int since_m = 1000, since_a = 1000;

   function automatic void model_clear();
      hist.delete();
      since_m = 1000;
      since_a = 1000;
   endfunction

   function automatic void model_step(bit s, bit b, bit c);
      bit ones_ok, alt_ok;
      if (c) begin model_clear(); return; end
      if (!s) return;
      hist.push_back(b);
      if (hist.size() > 32) void'(hist.pop_front());
      ones_ok = (hist.size() == 32);
      alt_ok  = (hist.size() == 32);
      for (int i = 0; i < hist.size(); i++) begin
         if (!hist[i]) ones_ok = 0;
         if (i > 0 && hist[i] == hist[i-1]) alt_ok = 0;
      end
      if (ones_ok) since_m = 0; else if (since_m < 1000) since_m++;
      if (alt_ok)  since_a = 0; else if (since_a < 1000) since_a++;
   endfunction

   task automatic cmp(string tag);
      checks++;
      if (mark_det !== (since_m < 12) || alt_det !== (since_a < 12)) begin
         errors++;
         $display("FAIL %s model: mark/alt actual %b%b expected %b%b", tag,
            mark_det, alt_det, since_m < 12, since_a < 12);
      end
   endtask

   task automatic expect_flags(bit m, bit a, string tag);
      checks++;
      if (mark_det !== m || alt_det !== a) begin
         errors++;
         $display("FAIL %s: mark/alt actual %b%b expected %b%b", tag, mark_det, alt_det, m, a);
      end
   endtask

   task automatic cyc(bit s, bit b, bit c, string tag);
      bit_stb = s; rx_bit = b; cfg_chg = c;
      @(posedge clk);
      model_step(s, b, c);
      @(negedge clk);
      bit_stb = 0; cfg_chg = 0;
      cmp(tag);
   endtask

   task automatic feed(int n, bit first, bit alt, string tag);
      bit b = first;
      for (int i = 0; i < n; i++) begin
         cyc(1, b, 0, tag);
         if (alt) b = ~b;
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_flags(0, 0, "R1 in reset");
      rst_n = 1;
      cyc(0, 0, 0, "R1");
      expect_flags(0, 0, "R1 after reset");

      feed(31, 1, 0, "R2");
      expect_flags(0, 0, "R2 31 ones");
      feed(1, 1, 0, "R2");
      expect_flags(1, 0, "R2 32 ones");

      feed(11, 0, 0, "R5");
      expect_flags(1, 0, "R5 11 after");
      for (int i = 0; i < 4; i++) begin
         cyc(0, i[0], 0, "R7");
         expect_flags(1, 0, "R7 no strobe");
      end
      feed(1, 0, 0, "R5");
      expect_flags(0, 0, "R5 12th strobe");

      cyc(0, 0, 1, "R6");
      feed(32, 0, 1, "R3");
      expect_flags(0, 1, "R3 start 0");
      cyc(1, 1, 1, "R6");
      expect_flags(0, 0, "R6 clear with strobe");
      feed(31, 1, 1, "R3");
      expect_flags(0, 0, "R3 31 alt");
      feed(1, 0, 1, "R3");
      expect_flags(0, 1, "R3 start 1");

      cyc(0, 0, 1, "R6");
      feed(20, 0, 1, "R4");
      cyc(1, 1, 0, "R4");
      feed(30, 0, 1, "R4");
      expect_flags(0, 0, "R4 before requal");
      feed(1, 0, 1, "R4");
      expect_flags(0, 1, "R4 break bit counts");

      cyc(0, 0, 1, "R6");
      feed(20, 1, 0, "R4");
      cyc(1, 0, 0, "R4");
      feed(31, 1, 0, "R4");
      expect_flags(0, 0, "R4 ones restart");
      feed(1, 1, 0, "R4");
      expect_flags(1, 0, "R4 ones requal");

      feed(100, 1, 0, "R8");
      expect_flags(1, 0, "R8 long mark");
      cyc(0, 0, 1, "R6");
      feed(100, 1, 1, "R8");
      expect_flags(0, 1, "R8 long alt");

      for (int i = 0; i < 3000; i++) begin
         int r = $urandom_range(0, 99);
         if (r < 1) cyc(1, 1, 1, "R6");
         else if (r < 20) cyc(0, r[0], 0, "R7");
         else if (r < 60) cyc(1, (since_a < 1000) ? ~rx_bit : r[1], 0, "R3");
         else cyc(1, (r < 97) ? 1'b1 : 1'b0, 0, "R5");
      end

      done = 1;
      summary();
   end
endmodule